// File: doc/BRIEF.md
# Controller interrupt status aggregator

This block gathers the interrupt sources of an audio-style controller that owns several DMA streams and folds them into one global status word and one interrupt output. The sources are a response-ring interrupt flag, a response-ring overrun flag, a vector of codec state-change bits gated by a matching vector of wake enables, and one buffer-complete flag per stream. The block owns two registers: an interrupt control word, which holds a per-source enable for each status bit plus a global enable, and a status word whose bits software clears by writing ones.

The status word is a snapshot. It is recomputed only when the surrounding register file signals an evaluation event (`eval_i`, raised whenever software writes wake enables, state-change status or response-ring status) or when the control word is written. Between those events, source changes leave it untouched. The interrupt is active when the status summary bit and the control global-enable bit are both set. The `msi_en_i` input selects whether that condition drives a level line or a single one-clock message pulse on each rise of the active condition.

Top module: `irq_status_agg`

## Requirements
- R1: While reset is asserted and after its release with no other stimulus, the control word, the status word, `irq_o` and `msi_o` are all zero.
- R2: A control write stores `wdata_i` bits 31, 30 and NSTREAM-1:0 (bits 31:30 and 7:0 with the default of eight streams). All other control bits read as zero.
- R3: On evaluation, status bit 30 equals the OR of the response interrupt flag, the response overrun flag and every state-change bit whose wake enable is set.
- R4: On evaluation, status bit i equals the buffer-complete flag of stream i, for every stream i.
- R5: On evaluation, status bit 31 is set exactly when some status bit among 30:0 of the new value is also set in the control word.
- R6: Without an evaluation, a control write or a status write, the status word holds its value whatever the source inputs do.
- R7: A control write triggers an evaluation that uses the newly written control value, in the same cycle.
- R8: A status write clears each of status bits 31, 30 and NSTREAM-1:0 where `wdata_i` has a one and leaves the others. When an evaluation happens in the same cycle, the evaluated value is stored and the clear is ignored.
- R9: `irq_o` is high exactly when status bit 31 and control bit 31 are both set and `msi_en_i` is low.
- R10: With `msi_en_i` high, `msi_o` is high for exactly one cycle after the active condition (status bit 31 and control bit 31) rises. It stays low while the condition is held or while `msi_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_irq_i | input | 1 | Response-ring interrupt flag |
| resp_ovf_i | input | 1 | Response-ring overrun flag |
| chg_sts_i | input | NCODEC | Codec state-change bits |
| wake_en_i | input | NCODEC | Wake enable per state-change bit |
| stream_done_i | input | NSTREAM | Buffer-complete flag per stream |
| msi_en_i | input | 1 | Selects message pulse (1) or level line (0) |
| eval_i | input | 1 | Re-evaluate the status word this cycle |
| ctrl_we_i | input | 1 | Write `wdata_i` into the control word |
| sts_we_i | input | 1 | Write-one-to-clear into the status word |
| wdata_i | input | 32 | Write data |
| ctrl_o | output | 32 | Current control word |
| sts_o | output | 32 | Current status word |
| irq_o | output | 1 | Level interrupt |
| msi_o | output | 1 | One-cycle message pulse |

## Verification
The hardest situation to reach is a second message pulse. The active condition must first fall, through a status clear or an evaluation with the sources withdrawn, and then rise again while `msi_en_i` stays high. Random stimulus seldom produces that sequence on its own. Directed steps drive it explicitly: pulse, hold, clear, re-evaluate. The same directed steps also collide a status clear with an evaluation in one cycle. A seeded random phase then mixes evaluations, writes of both registers, source changes and mode switches, and every output is compared each cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int REG_W   = 32;
  localparam int GLB_BIT = 31;
  localparam int SUM_BIT = 30;

  // Bits of the control and status words that exist for a given stream count.
  function automatic logic [REG_W-1:0] live_bits(input int nstream);
    logic [REG_W-1:0] m;
    m = '0;
    m[GLB_BIT] = 1'b1;
    m[SUM_BIT] = 1'b1;
    for (int k = 0; k < SUM_BIT; k++) begin
      if (k < nstream) m[k] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_src_gather.sv
module irq_src_gather #(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 15
) (
  input  logic               resp_irq,
  input  logic               resp_ovf,
  input  logic [NCODEC-1:0]  chg_sts,
  input  logic [NCODEC-1:0]  wake_en,
  input  logic [NSTREAM-1:0] stream_done,
  output logic [irqagg_pkg::SUM_BIT:0] src_vec
);
  import irqagg_pkg::*;

  logic wake_hit;
  assign wake_hit = |(chg_sts & wake_en);

  assign src_vec[SUM_BIT] = resp_irq | resp_ovf | wake_hit;

  for (genvar g = 0; g < SUM_BIT; g++) begin : g_bit
    if (g < NSTREAM) begin : g_strm
      assign src_vec[g] = stream_done[g];
    end else begin : g_none
      assign src_vec[g] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NSTREAM = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_we,
  input  logic                          sts_we,
  input  logic                          eval,
  input  logic [irqagg_pkg::REG_W-1:0]  wdata,
  input  logic [irqagg_pkg::SUM_BIT:0]  src_vec,
  output logic [irqagg_pkg::REG_W-1:0]  ctrl_q,
  output logic [irqagg_pkg::REG_W-1:0]  sts_q
);
  import irqagg_pkg::*;

  localparam logic [REG_W-1:0] LIVE = live_bits(NSTREAM);

  logic [REG_W-1:0] ctrl_d, sts_d, fresh;
  logic             ctrl_en, sts_en, do_eval;

  assign do_eval = eval | ctrl_we;
  assign ctrl_en = ctrl_we;
  assign sts_en  = do_eval | sts_we;

  always_comb begin
    ctrl_d = ctrl_we ? (wdata & LIVE) : ctrl_q;
    fresh  = '0;
    fresh[SUM_BIT:0] = src_vec;
    fresh[GLB_BIT]   = |(src_vec & ctrl_d[SUM_BIT:0]);
    if (do_eval)      sts_d = fresh;
    else if (sts_we)  sts_d = sts_q & ~(wdata & LIVE);
    else              sts_d = sts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sts_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (sts_en)  sts_q  <= sts_d;
    end
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic msi_en,
  input  logic sts_glb,
  input  logic ctrl_glb,
  output logic irq,
  output logic msi
);
  logic active, active_prev_q, active_prev_d;

  assign active        = sts_glb & ctrl_glb;
  assign active_prev_d = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_prev_q <= 1'b0;
    else        active_prev_q <= active_prev_d;
  end

  assign irq = active & ~msi_en;
  assign msi = active & ~active_prev_q & msi_en;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               resp_irq_i,
  input  logic               resp_ovf_i,
  input  logic [NCODEC-1:0]  chg_sts_i,
  input  logic [NCODEC-1:0]  wake_en_i,
  input  logic [NSTREAM-1:0] stream_done_i,
  input  logic               msi_en_i,
  input  logic               eval_i,
  input  logic               ctrl_we_i,
  input  logic               sts_we_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        ctrl_o,
  output logic [31:0]        sts_o,
  output logic               irq_o,
  output logic               msi_o
);
  import irqagg_pkg::*;

  logic [SUM_BIT:0] src_vec;

  irq_src_gather #(.NSTREAM(NSTREAM), .NCODEC(NCODEC)) u_gather (
    .resp_irq    (resp_irq_i),
    .resp_ovf    (resp_ovf_i),
    .chg_sts     (chg_sts_i),
    .wake_en     (wake_en_i),
    .stream_done (stream_done_i),
    .src_vec     (src_vec)
  );

  irq_status_reg #(.NSTREAM(NSTREAM)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_we (ctrl_we_i),
    .sts_we  (sts_we_i),
    .eval    (eval_i),
    .wdata   (wdata_i),
    .src_vec (src_vec),
    .ctrl_q  (ctrl_o),
    .sts_q   (sts_o)
  );

  irq_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .msi_en   (msi_en_i),
    .sts_glb  (sts_o[GLB_BIT]),
    .ctrl_glb (ctrl_o[GLB_BIT]),
    .irq      (irq_o),
    .msi      (msi_o)
  );
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
  parameter int NSTREAM = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        msi_en_i,
  input logic        eval_i,
  input logic        ctrl_we_i,
  input logic        sts_we_i,
  input logic [31:0] wdata_i,
  input logic [31:0] ctrl_o,
  input logic [31:0] sts_o,
  input logic        irq_o,
  input logic        msi_o
);
  localparam logic [31:0] LIVE = irqagg_pkg::live_bits(NSTREAM);

  // R2
  ctrl_dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o & ~LIVE) == 32'd0);

  // R5
  glb_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i || ctrl_we_i) |=> (sts_o[31] == |(sts_o[30:0] & ctrl_o[30:0])));

  // R6
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_i && !ctrl_we_i && !sts_we_i) |=> $stable(sts_o));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we_i && !eval_i && !ctrl_we_i) |=> ((sts_o & $past(wdata_i & LIVE)) == 32'd0));

  // R9
  level_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en_i |-> !irq_o);

  // R10
  msi_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_o |=> !msi_o);

  // R10
  msi_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_o |-> (sts_o[31] && ctrl_o[31] && msi_en_i));
endmodule

bind irq_status_agg irq_status_agg_chk #(.NSTREAM(NSTREAM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msi_en_i  (msi_en_i),
  .eval_i    (eval_i),
  .ctrl_we_i (ctrl_we_i),
  .sts_we_i  (sts_we_i),
  .wdata_i   (wdata_i),
  .ctrl_o    (ctrl_o),
  .sts_o     (sts_o),
  .irq_o     (irq_o),
  .msi_o     (msi_o)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
  localparam int NS = 8;
  localparam int NC = 15;
  localparam logic [31:0] LIVE = 32'hC000_00FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          resp_irq = 1'b0, resp_ovf = 1'b0;
  logic [NC-1:0] chg = '0, wake = '0;
  logic [NS-1:0] done = '0;
  logic          msi_en = 1'b0, eval = 1'b0, ctrl_we = 1'b0, sts_we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   ctrl_o, sts_o;
  logic          irq_o, msi_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_ctrl = '0, m_sts = '0;
  logic        m_prev = 1'b0;

  always #4 clk = ~clk;

  irq_status_agg #(.NSTREAM(NS), .NCODEC(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .resp_irq_i(resp_irq), .resp_ovf_i(resp_ovf),
    .chg_sts_i(chg), .wake_en_i(wake), .stream_done_i(done), .msi_en_i(msi_en),
    .eval_i(eval), .ctrl_we_i(ctrl_we), .sts_we_i(sts_we), .wdata_i(wdata),
    .ctrl_o(ctrl_o), .sts_o(sts_o), .irq_o(irq_o), .msi_o(msi_o));

  function automatic logic [31:0] model_eval(input logic [31:0] c);
    logic [31:0] s;
    s = '0;
    s[30]  = resp_irq | resp_ovf | (|(chg & wake));  // R3
    s[7:0] = done;                                    // R4
    s[31]  = |(s[30:0] & c[30:0]);                    // R5
    return s;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Applies the current drive values across one rising edge and checks all outputs.
  task automatic cyc(input string tag);
    logic [31:0] nc, ns;
    logic        np, act;
    nc = ctrl_we ? (wdata & LIVE) : m_ctrl;
    if (eval || ctrl_we) ns = model_eval(nc);
    else if (sts_we)     ns = m_sts & ~(wdata & LIVE);
    else                 ns = m_sts;
    np = m_sts[31] & m_ctrl[31];
    @(posedge clk);
    #1;
    m_ctrl = nc; m_sts = ns; m_prev = np;
    act = m_sts[31] & m_ctrl[31];
    chk(tag, "ctrl", ctrl_o, m_ctrl);
    chk(tag, "sts", sts_o, m_sts);
    chk("R9", "irq", {31'd0, irq_o}, {31'd0, act & ~msi_en});
    chk("R10", "msi", {31'd0, msi_o}, {31'd0, act & ~m_prev & msi_en});
    @(negedge clk);
    eval = 1'b0; ctrl_we = 1'b0; sts_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    // R1 during reset
    chk("R1", "ctrl in reset", ctrl_o, 32'd0);
    chk("R1", "sts in reset", sts_o, 32'd0);
    chk("R1", "outs in reset", {30'd0, irq_o, msi_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R1");

    // R2 dead control bits
    ctrl_we = 1'b1; wdata = 32'hFFFF_FFFF; cyc("R2");
    // R3 summary from wake-gated change bit only
    chg = 15'h0004; wake = 15'h0004; eval = 1'b1; cyc("R3");
    // R3 change bit without wake enable: summary clear
    wake = 15'h0001; eval = 1'b1; cyc("R3");
    // R3 overrun alone
    resp_ovf = 1'b1; eval = 1'b1; cyc("R3");
    resp_ovf = 1'b0;
    // R4 stream bits
    done = 8'hA5; eval = 1'b1; cyc("R4");
    // R6 source changes without evaluation
    done = 8'h00; resp_irq = 1'b1; cyc("R6");
    cyc("R6");
    // R7 control write re-evaluates with new enables (stream 1 only)
    done = 8'h02; resp_irq = 1'b0; ctrl_we = 1'b1; wdata = 32'h0000_0001; cyc("R7");
    ctrl_we = 1'b1; wdata = 32'h8000_0002; cyc("R7");
    // R8 clear of stream bit and global bit
    sts_we = 1'b1; wdata = 32'h8000_0002; cyc("R8");
    // R8 clear colliding with evaluation: evaluation wins
    sts_we = 1'b1; eval = 1'b1; wdata = 32'hFFFF_FFFF; cyc("R8");
    // R10 pulse on rise in message mode
    msi_en = 1'b1;
    sts_we = 1'b1; wdata = 32'h8000_0000; cyc("R10");
    eval = 1'b1; cyc("R10");
    cyc("R10");
    cyc("R10");
    // R10 second pulse after fall
    sts_we = 1'b1; wdata = 32'h8000_0000; cyc("R10");
    eval = 1'b1; cyc("R10");
    // R9 back to level mode with condition held
    msi_en = 1'b0; cyc("R9");
    // R5 global enable off: status summary still set, no interrupt
    ctrl_we = 1'b1; wdata = 32'h0000_0002; cyc("R5");

    // Random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      resp_irq = ($urandom % 6) == 0;
      resp_ovf = ($urandom % 8) == 0;
      chg  = NC'($urandom);
      wake = NC'($urandom) & NC'($urandom);
      done = NS'($urandom) & NS'($urandom);
      if ((i % 16) == 0) msi_en = $urandom % 2;
      op = $urandom % 6;
      wdata = $urandom;
      if ($urandom % 2) wdata[31] = 1'b1;
      eval    = (op == 0) || (op == 4);
      ctrl_we = (op == 1);
      sts_we  = (op == 2) || (op == 4);
      cyc("R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule